// File: doc/BRIEF.md
# Parallel OTP Memory Read Sequencer

This block sits on the host side of an asynchronous, word-wide one-time-programmable memory that has separate active-low chip-select and output-enable inputs. A client hands it an 18-bit word address through a valid/ready port. The block puts the address on the memory pins and pulls the chip select low. It pulls the output enable low a set number of cycles later. It then waits until the address-to-data, select-to-data and enable-to-data delays have all run out, registers the 16-bit word and gives it back with a one-cycle strobe.

The three access delays run on separate saturating timers. A read therefore ends as soon as the slowest of the three has run out, and a late output enable costs nothing while it stays inside the slack of the other two. The block raises both controls at the same edge that captures the data, because the memory gives no output hold time. A float window then keeps the data bus reserved until the memory has stopped driving it. While no read is in progress the memory is kept in standby, with both controls high.

Every delay is given in nanoseconds and turned into clock cycles by rounding up at the configured clock period. With the defaults (10 ns clock, 120/120/35/30 ns) the counts are 12 cycles for access, 4 for output enable and 3 for float. The output enable lags the chip select by 2 cycles.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: During and after reset, mem_ce_n and mem_oe_n are 1, rsp_valid is 0, and req_rdy and bus_idle are 1.
- R2: A request is accepted at a rising edge where req_valid and req_rdy are both 1. From the next cycle mem_addr holds the accepted address and mem_ce_n is 0.
- R3: mem_oe_n falls OE_LAG_CYC cycles after mem_ce_n falls, or at the same edge when the lag is 0. Between the two edges the memory sits in output-disable (mem_ce_n=0, mem_oe_n=1).
- R4: rsp_valid rises N cycles after the accepting edge. N = max(ACC, CE, OE_LAG_CYC + OE), and each of ACC, CE and OE is ceil(ns*1000 / CLK_PERIOD_PS); the default N is 12.
- R5: rsp_data is the value on mem_dq at the capture edge. It holds that value until the next capture.
- R6: rsp_valid is high for exactly one cycle. In that cycle mem_ce_n and mem_oe_n are both already 1.
- R7: mem_addr does not change while mem_ce_n stays 0.
- R8: After the controls rise, bus_idle and req_rdy stay 0 for DF = ceil(T_DF_NS*1000 / CLK_PERIOD_PS) cycles, which is 3 by default. A request raised during that window is held off, with the chip select high, and is accepted at the first edge where req_rdy is 1.
- R9: Whenever req_rdy is 1, the memory is in standby (mem_ce_n=1, mem_oe_n=1).
- R10: mem_oe_n is never 0 while mem_ce_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Read request present |
| req_addr | input | 18 | Word address of the request |
| req_rdy | output | 1 | Block idle and able to take a request |
| rsp_valid | output | 1 | One-cycle strobe marking captured data |
| rsp_data | output | 16 | Captured data word |
| mem_addr | output | 18 | Address pins of the memory |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq | input | 16 | Data pins of the memory |
| bus_idle | output | 1 | Memory no longer drives the data bus; other agents may use it |

## Verification
The assertions check on every cycle that the memory controls obey their ordering rules. The output enable is never active without the chip select, and the address stays put while the chip select is low. The standby state holds whenever the block is ready, the controls are already released when the response strobe fires, the strobe lasts one cycle, and an accepted address reaches the pins on the next cycle. Some properties can only be shown by the bench's scenarios, because they depend on a memory model with real delays: that the data is captured exactly when all three delays have run out, the exact access and float counts, the output-disable lag, and that a request held during the float window is accepted at the first free edge.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;

    typedef enum logic [1:0] {
        RD_STANDBY = 2'd0,
        RD_ACCESS  = 2'd1,
        RD_FLOAT   = 2'd2
    } rd_state_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
    } rd_pins_t;

    localparam int unsigned NUM_TMR = 5;
    localparam int unsigned TMR_ACC = 0;
    localparam int unsigned TMR_CE  = 1;
    localparam int unsigned TMR_OE  = 2;
    localparam int unsigned TMR_LAG = 3;
    localparam int unsigned TMR_DF  = 4;

    function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                                 input int unsigned period_ps);
        return (ns * 1000 + period_ps - 1) / period_ps;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/eprom_delay_timer.sv
module eprom_delay_timer #(
    parameter int unsigned THRESH = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    localparam int unsigned W = $clog2(THRESH + 1) + 1;
    localparam logic [W-1:0] LAST = (THRESH == 0) ? '0 : W'(THRESH - 1);

    logic [W-1:0] cnt;

    // Counts edges seen while run is held; done means THRESH periods have
    // elapsed at the coming edge.
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt < LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = run && (cnt >= LAST);

endmodule

// File: rtl/eprom_rd_seq.sv
module eprom_rd_seq
    import eprom_rd_pkg::*;
#(
    parameter int unsigned ADDR_W   = 18,
    parameter bit          LAG_ZERO = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    output logic               req_rdy,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               mem_ce_n,
    output logic               mem_oe_n,
    input  logic [NUM_TMR-1:0] tmr_done,
    output logic [NUM_TMR-1:0] tmr_run,
    output logic               cap_en,
    output logic               bus_idle
);
    rd_state_e          state;
    rd_pins_t           pins;
    logic [ADDR_W-1:0]  addr_q;

    assign cap_en = (state == RD_ACCESS) && tmr_done[TMR_ACC]
                  && tmr_done[TMR_CE] && tmr_done[TMR_OE];

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RD_STANDBY;
            pins  <= '{ce_n: 1'b1, oe_n: 1'b1};
            addr_q <= '0;
        end else begin
            case (state)
                RD_STANDBY: begin
                    if (req_valid) begin
                        addr_q    <= req_addr;
                        pins.ce_n <= 1'b0;
                        pins.oe_n <= !LAG_ZERO;
                        state     <= RD_ACCESS;
                    end
                end
                RD_ACCESS: begin
                    if (cap_en) begin
                        pins  <= '{ce_n: 1'b1, oe_n: 1'b1};
                        state <= RD_FLOAT;
                    end else if (pins.oe_n && tmr_done[TMR_LAG]) begin
                        pins.oe_n <= 1'b0;
                    end
                end
                RD_FLOAT: begin
                    if (tmr_done[TMR_DF]) begin
                        state <= RD_STANDBY;
                    end
                end
                default: state <= RD_STANDBY;
            endcase
        end
    end

    always_comb begin
        tmr_run          = '0;
        tmr_run[TMR_ACC] = (state == RD_ACCESS);
        tmr_run[TMR_CE]  = !pins.ce_n;
        tmr_run[TMR_LAG] = !pins.ce_n;
        tmr_run[TMR_OE]  = !pins.oe_n;
        tmr_run[TMR_DF]  = (state == RD_FLOAT);
    end

    assign req_rdy  = (state == RD_STANDBY);
    assign bus_idle = (state == RD_STANDBY);
    assign mem_addr = addr_q;
    assign mem_ce_n = pins.ce_n;
    assign mem_oe_n = pins.oe_n;

    // R10: output enable only inside an active chip select
    p_oe_inside_ce_r10: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !mem_ce_n);

    // R7: address frozen while selected
    p_addr_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    // R9: ready implies standby
    p_standby_r9: assert property (@(posedge clk) disable iff (rst)
        req_rdy |-> (mem_ce_n && mem_oe_n));

    // R2: accepted address reaches the pins next cycle with CE low
    p_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_rdy) |=> (!mem_ce_n && mem_addr == $past(req_addr)));

    // R8: release of CE opens a gap, no acceptance at that point
    p_gap_after_release_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_ce_n) |-> !req_rdy);

endmodule

// File: rtl/eprom_rd_capture.sv
module eprom_rd_capture #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] mem_dq,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= cap_en;
            if (cap_en) begin
                rsp_data <= mem_dq;
            end
        end
    end

    // R6: strobe lasts a single cycle
    p_single_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R5: data held between captures
    p_data_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !$past(cap_en) |-> $stable(rsp_data));

endmodule

// File: rtl/eprom_rd_ctrl.sv
module eprom_rd_ctrl
    import eprom_rd_pkg::*;
#(
    parameter int unsigned ADDR_W        = 18,
    parameter int unsigned DATA_W        = 16,
    parameter int unsigned CLK_PERIOD_PS = 10000,
    parameter int unsigned T_ACC_NS      = 120,
    parameter int unsigned T_CE_NS       = 120,
    parameter int unsigned T_OE_NS       = 35,
    parameter int unsigned T_DF_NS       = 30,
    parameter int unsigned OE_LAG_CYC    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_rdy,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    input  logic [DATA_W-1:0] mem_dq,
    output logic              bus_idle
);
    localparam int unsigned ACC_C = ns_to_cycles(T_ACC_NS, CLK_PERIOD_PS);
    localparam int unsigned CE_C  = ns_to_cycles(T_CE_NS,  CLK_PERIOD_PS);
    localparam int unsigned OE_C  = ns_to_cycles(T_OE_NS,  CLK_PERIOD_PS);
    localparam int unsigned DF_C  = ns_to_cycles(T_DF_NS,  CLK_PERIOD_PS);
    localparam int unsigned THR [NUM_TMR] = '{ACC_C, CE_C, OE_C, OE_LAG_CYC, DF_C};

    logic [NUM_TMR-1:0] tmr_run;
    logic [NUM_TMR-1:0] tmr_done;
    logic               cap_en;

    eprom_rd_seq #(
        .ADDR_W   (ADDR_W),
        .LAG_ZERO (OE_LAG_CYC == 0)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_rdy   (req_rdy),
        .mem_addr  (mem_addr),
        .mem_ce_n  (mem_ce_n),
        .mem_oe_n  (mem_oe_n),
        .tmr_done  (tmr_done),
        .tmr_run   (tmr_run),
        .cap_en    (cap_en),
        .bus_idle  (bus_idle)
    );

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
        eprom_delay_timer #(
            .THRESH (THR[g])
        ) u_tmr (
            .clk  (clk),
            .rst  (rst),
            .run  (tmr_run[g]),
            .done (tmr_done[g])
        );
    end

    eprom_rd_capture #(
        .DATA_W (DATA_W)
    ) u_cap (
        .clk       (clk),
        .rst       (rst),
        .cap_en    (cap_en),
        .mem_dq    (mem_dq),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    // R6: controls already released when the strobe is seen
    p_released_at_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (mem_ce_n && mem_oe_n));

    // R8: bus stays reserved while the strobe is out
    p_no_idle_at_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !bus_idle);

endmodule

// File: tb/eprom_rd_ctrl_test.sv
module eprom_rd_ctrl_test;
    localparam int ACC = 12, CEC = 12, OEC = 4, LAG = 2, DF = 3;
    localparam int LAT = (ACC > CEC ? (ACC > LAG + OEC ? ACC : LAG + OEC)
                                    : (CEC > LAG + OEC ? CEC : LAG + OEC));

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [17:0] req_addr = '0;
    logic        req_rdy, rsp_valid, mem_ce_n, mem_oe_n, bus_idle;
    logic [15:0] rsp_data, dq_drv;
    logic [17:0] mem_addr;

    int checks = 0, fails = 0;
    bit done_flag = 0;

    always #10 clk = ~clk;

    eprom_rd_ctrl uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_rdy(req_rdy), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_dq(dq_drv), .bus_idle(bus_idle)
    );

    function automatic logic [15:0] pat(input logic [17:0] a);
        return a[15:0] ^ {14'h1C3B, a[17:16]};
    endfunction

    // memory model and protocol monitor, updated away from the active edge
    int a_age = 255, c_age = 0, o_age = 0, f_age = 255, dis_cnt = 0;
    int float_bad = 0, addr_bad = 0, stby_bad = 0, oe_bad = 0;
    logic [17:0] prev_addr = '0;
    logic prev_ce_n = 1'b1, prev_oe_n = 1'b1, prev_drv = 1'b0;

    always @(negedge clk) begin
        logic drv;
        a_age = (mem_addr != prev_addr) ? 0 : (a_age < 255 ? a_age + 1 : a_age);
        c_age = (mem_ce_n || prev_ce_n) ? 0 : c_age + 1;
        o_age = (mem_oe_n || prev_oe_n) ? 0 : o_age + 1;
        if (!mem_ce_n && prev_ce_n) dis_cnt = 0;
        if (!mem_ce_n && mem_oe_n) dis_cnt++;
        if (!rst) begin
            if (!mem_ce_n && !prev_ce_n && mem_addr != prev_addr) addr_bad++;
            if (req_rdy && (!mem_ce_n || !mem_oe_n)) stby_bad++;
            if (mem_ce_n && !mem_oe_n) oe_bad++;
        end
        drv = !mem_ce_n && !mem_oe_n;
        if (drv) f_age = 0;
        else if (prev_drv) f_age = 0;
        else if (f_age < 255) f_age++;
        if (bus_idle && (drv || f_age < DF)) float_bad++;
        dq_drv = (drv && a_age + 1 >= ACC && c_age + 1 >= CEC && o_age + 1 >= OEC)
                 ? pat(mem_addr) : ~pat(mem_addr);
        prev_addr = mem_addr; prev_ce_n = mem_ce_n; prev_oe_n = mem_oe_n; prev_drv = drv;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one read; early=1 returns right after the strobe, leaving the gap open
    task automatic do_read(input logic [17:0] a, input bit early, input bit prev_early);
        int w = 0, n = 0, g = 0;
        bit held_ok = 1;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        while (!req_rdy && w < 50) begin
            if (!mem_ce_n) held_ok = 0;
            @(negedge clk); w++;
        end
        if (prev_early) begin
            chk(w == DF - 1, "R8 held-off wait", w, DF - 1);
            chk(held_ok, "R8 CE high while held", held_ok, 1);
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk(!mem_ce_n && mem_addr == a, "R2 accept", {mem_ce_n, mem_addr}, {1'b0, a});
        do begin @(negedge clk); n++; end while (!rsp_valid && n < 100);
        chk(n == LAT, "R4 latency", n, LAT);
        chk(rsp_data == pat(a), "R5 data", rsp_data, pat(a));
        chk(mem_ce_n && mem_oe_n, "R6 released at strobe", {mem_ce_n, mem_oe_n}, 2'b11);
        chk(dis_cnt == LAG, "R3 output-disable lag", dis_cnt, LAG);
        if (!early) begin
            @(negedge clk);
            chk(!rsp_valid && rsp_data == pat(a), "R6 R5 strobe width and hold",
                {rsp_valid, rsp_data}, {1'b0, pat(a)});
            g = 1;
            while (!req_rdy && g < 50) begin @(negedge clk); g++; end
            chk(g == DF && bus_idle, "R8 float gap", g, DF);
        end
    endtask

    initial begin
        #(20 * 150000);
        chk(0, "watchdog", 0, 1);
        if (!done_flag) begin
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        bit pe = 0;
        seed = $urandom(32'd915);
        repeat (3) @(negedge clk);
        chk(mem_ce_n && mem_oe_n && !rsp_valid && req_rdy && bus_idle, "R1 in reset",
            {mem_ce_n, mem_oe_n, rsp_valid, req_rdy, bus_idle}, 5'b11011);
        rst = 1'b0;
        @(negedge clk);
        chk(mem_ce_n && mem_oe_n && !rsp_valid && req_rdy && bus_idle, "R1 after reset",
            {mem_ce_n, mem_oe_n, rsp_valid, req_rdy, bus_idle}, 5'b11011);
        // R9: idle with no request keeps standby
        repeat (5) @(negedge clk);
        chk(mem_ce_n && mem_oe_n, "R9 standby idle", {mem_ce_n, mem_oe_n}, 2'b11);
        // directed corners: address extremes, repeat address, early request in gap
        do_read(18'h00000, 0, 0);
        do_read(18'h3FFFF, 0, 0);
        do_read(18'h3FFFF, 1, 0);
        do_read(18'h2A5C3, 0, 1);
        // random traffic
        for (int i = 0; i < 60; i++) begin
            bit e;
            e = ($urandom % 3) == 0;
            do_read(18'($urandom), e, pe);
            pe = e;
            if (!e) repeat ($urandom % 4) @(negedge clk);
        end
        if (pe) do_read(18'h01234, 0, 1);
        repeat (5) @(negedge clk);
        chk(float_bad == 0, "R8 bus idle only after float", float_bad, 0);
        chk(addr_bad == 0, "R7 address stable", addr_bad, 0);
        chk(stby_bad == 0, "R9 standby when ready", stby_bad, 0);
        chk(oe_bad == 0, "R10 OE inside CE", oe_bad, 0);
        done_flag = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule